// File: doc/BRIEF.md
# Clock Redundancy Event Counter Unit

This block watches a redundant pair of timing references and the PLL that locks to them, and keeps a tally of every alarm transition. Each cycle it may receive one byte of transition causes: losses and returns of the primary and secondary references, entry to and exit from holdover, and loss and recovery of lock. It routes each cause to one of eleven saturating counters. When a loss is reported, the counter it lands in depends on the live alarm of the other reference.

The block also owns the redundant-reference select bit. A returning primary drives the bit to 1 and a returning secondary drives it to 0. Holdover entry starts a one-shot timer and records the select bit and the active-reference indicator. When the timer expires, the block compares the recorded indicator with the live one to detect and classify an automatic switchover. An event-ready flag tells a reader that a new tally is available. After fetching the counter bank, the reader pulses a clear that zeroes every counter and drops the flag in one cycle.

Top module: `clk_redund_evt_cnt`

## Requirements
- R1: Cause bit 0 (primary loss began) increments counter 0 (both lost) when `sec_lost_alarm` is 1, and counter 1 (primary lost) otherwise.
- R2: Cause bit 2 (secondary loss began) increments counter 0 when `pri_lost_alarm` is 1, and counter 2 (secondary lost) otherwise.
- R3: Cause bit 1 (primary returned) increments counter 3 and sets `ref_sel` to 1. Cause bit 3 (secondary returned) increments counter 4 and sets `ref_sel` to 0. When both arrive together, `ref_sel` ends at 0. `ref_sel` resets to 0.
- R4: Cause bit 5 (holdover ended) increments counter 8, bit 6 (lock lost) increments counter 9, and bit 7 (lock regained) increments counter 10. All outputs update on the clock edge that samples the event.
- R5: An event byte that is non-zero and has bit 4 clear sets `evt_ready` on the edge that samples it.
- R6: Cause bit 4 (holdover began) increments counter 7, records `ref_sel` and `ref_active`, and starts a timer. `evt_ready` is not set by that event; it is set exactly TMR_CYCLES edges later.
- R7: When the timer expires, a live `ref_active` that differs from the recorded one increments counter 5 (switch to primary) if the recorded `ref_sel` was 1, and counter 6 otherwise. If they match, neither counter moves.
- R8: A `rd_clr` pulse zeroes all eleven counters and clears `evt_ready`. An increment or ready-set in the same cycle is applied after the clear.
- R9: Counters hold at all-ones instead of wrapping.
- R10: A new holdover entry while the timer is running restarts the full interval and takes a fresh record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Cause byte valid this cycle |
| evt_cause | input | 8 | Transition cause bits, positions as in R1 to R6 |
| pri_lost_alarm | input | 1 | Live primary-lost alarm |
| sec_lost_alarm | input | 1 | Live secondary-lost alarm |
| ref_active | input | 1 | Live active-reference indicator |
| rd_clr | input | 1 | Reader finished; clear counters and flag |
| ref_sel | output | 1 | Redundant-reference select bit |
| evt_ready | output | 1 | New event tally available |
| cnt_flat | output | N_CNT*CNT_W | Counter k at bits [k*CNT_W +: CNT_W] |

## Verification
Loss events are sent with the other reference's alarm both clear and set, so the bench can tell the steered counter from the plain one. Return events are sent singly and together to show which select value wins. Holdover entries are run with the active indicator changing under each recorded select value and also held steady, which separates the two switchover counters from no switchover. Further cases cover an entry that restarts a running timer, an entry combined with other causes, a clear that coincides with an event, and a counter driven past its maximum.

// File: rtl/clk_evt_pkg.sv
package clk_evt_pkg;
  localparam int N_CNT = 11;
  localparam int N_CAUSE = 8;

  // cause byte bit positions
  localparam int C_PRI_DOWN = 0;
  localparam int C_PRI_UP   = 1;
  localparam int C_SEC_DOWN = 2;
  localparam int C_SEC_UP   = 3;
  localparam int C_HOLD_IN  = 4;
  localparam int C_HOLD_OUT = 5;
  localparam int C_LOCK_OFF = 6;
  localparam int C_LOCK_ON  = 7;

  typedef enum logic [3:0] {
    K_BOTH_LOST = 4'd0,
    K_PRI_LOST  = 4'd1,
    K_SEC_LOST  = 4'd2,
    K_PRI_BACK  = 4'd3,
    K_SEC_BACK  = 4'd4,
    K_SWO_PRI   = 4'd5,
    K_SWO_SEC   = 4'd6,
    K_HOLD_IN   = 4'd7,
    K_HOLD_OUT  = 4'd8,
    K_SYNC_LOST = 4'd9,
    K_SYNC_OK   = 4'd10
  } cnt_idx_e;
endpackage

// File: rtl/evt_decode.sv
module evt_decode
  import clk_evt_pkg::*;
(
  input  logic               evt_valid,
  input  logic [N_CAUSE-1:0] evt_cause,
  input  logic               pri_lost_alarm,
  input  logic               sec_lost_alarm,
  input  logic               swo_pri,
  input  logic               swo_sec,
  output logic [N_CNT-1:0]   inc,
  output logic               imm_ready,
  output logic               hold_start,
  output logic               sel_set,
  output logic               sel_clr
);
  logic [N_CAUSE-1:0] c;

  always_comb begin
    c = evt_valid ? evt_cause : '0;
    inc = '0;
    inc[K_BOTH_LOST] = (c[C_PRI_DOWN] && sec_lost_alarm) ||
                       (c[C_SEC_DOWN] && pri_lost_alarm);
    inc[K_PRI_LOST]  = c[C_PRI_DOWN] && !sec_lost_alarm;
    inc[K_SEC_LOST]  = c[C_SEC_DOWN] && !pri_lost_alarm;
    inc[K_PRI_BACK]  = c[C_PRI_UP];
    inc[K_SEC_BACK]  = c[C_SEC_UP];
    inc[K_SWO_PRI]   = swo_pri;
    inc[K_SWO_SEC]   = swo_sec;
    inc[K_HOLD_IN]   = c[C_HOLD_IN];
    inc[K_HOLD_OUT]  = c[C_HOLD_OUT];
    inc[K_SYNC_LOST] = c[C_LOCK_OFF];
    inc[K_SYNC_OK]   = c[C_LOCK_ON];
    hold_start = c[C_HOLD_IN];
    imm_ready  = (c != '0) && !c[C_HOLD_IN];
    sel_set    = c[C_PRI_UP];
    sel_clr    = c[C_SEC_UP];
  end
endmodule

// File: rtl/swo_timer.sv
module swo_timer #(
  parameter int TMR_CYCLES = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cur_sel,
  input  logic ref_active,
  output logic expire,
  output logic swo_pri,
  output logic swo_sec
);
  localparam int TW = $clog2(TMR_CYCLES + 1);
  localparam logic [TW-1:0] LOAD = TW'(TMR_CYCLES - 1);

  logic          run_q, run_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          snap_sel_q, snap_sel_d;
  logic          snap_act_q, snap_act_d;

  assign expire  = run_q && (cnt_q == '0) && !start;
  assign swo_pri = expire && (ref_active != snap_act_q) && snap_sel_q;
  assign swo_sec = expire && (ref_active != snap_act_q) && !snap_sel_q;

  always_comb begin
    run_d      = run_q;
    cnt_d      = cnt_q;
    snap_sel_d = snap_sel_q;
    snap_act_d = snap_act_q;
    if (start) begin
      run_d      = 1'b1;
      cnt_d      = LOAD;
      snap_sel_d = cur_sel;
      snap_act_d = ref_active;
    end else if (run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      cnt_q      <= '0;
      snap_sel_q <= 1'b0;
      snap_act_q <= 1'b0;
    end else begin
      run_q      <= run_d;
      cnt_q      <= cnt_d;
      snap_sel_q <= snap_sel_d;
      snap_act_q <= snap_act_d;
    end
  end

  // R10
  tmr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run_q && cnt_q == LOAD));
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = '1;
  logic [W-1:0] cnt_d;
  logic         en;

  always_comb begin
    en    = clr || (inc && cnt != MAXV);
    cnt_d = clr ? W'(inc) : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (en) cnt <= cnt_d;
  end

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXV && !clr) |=> cnt == MAXV);
  // R8
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc) |=> cnt == '0);
endmodule

// File: rtl/clk_redund_evt_cnt.sv
module clk_redund_evt_cnt
  import clk_evt_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int TMR_CYCLES = 2500000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   evt_valid,
  input  logic [7:0]             evt_cause,
  input  logic                   pri_lost_alarm,
  input  logic                   sec_lost_alarm,
  input  logic                   ref_active,
  input  logic                   rd_clr,
  output logic                   ref_sel,
  output logic                   evt_ready,
  output logic [N_CNT*CNT_W-1:0] cnt_flat
);
  logic [1:0]       rst_sync;
  logic             rst_ni;
  logic [N_CNT-1:0] inc;
  logic             imm_ready, hold_start, sel_set, sel_clr;
  logic             tmr_expire, swo_pri, swo_sec;
  logic             ref_sel_d, ready_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  evt_decode u_dec (
    .evt_valid(evt_valid), .evt_cause(evt_cause),
    .pri_lost_alarm(pri_lost_alarm), .sec_lost_alarm(sec_lost_alarm),
    .swo_pri(swo_pri), .swo_sec(swo_sec),
    .inc(inc), .imm_ready(imm_ready), .hold_start(hold_start),
    .sel_set(sel_set), .sel_clr(sel_clr)
  );

  swo_timer #(.TMR_CYCLES(TMR_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_ni), .start(hold_start), .cur_sel(ref_sel),
    .ref_active(ref_active), .expire(tmr_expire),
    .swo_pri(swo_pri), .swo_sec(swo_sec)
  );

  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
    sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_ni), .clr(rd_clr), .inc(inc[k]),
      .cnt(cnt_flat[k*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    ref_sel_d = sel_clr ? 1'b0 : (sel_set ? 1'b1 : ref_sel);
    ready_d   = (imm_ready || tmr_expire) ? 1'b1 :
                (rd_clr ? 1'b0 : evt_ready);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_sel   <= 1'b0;
      evt_ready <= 1'b0;
    end else begin
      ref_sel   <= ref_sel_d;
      evt_ready <= ready_d;
    end
  end

  // R3
  pri_back_sel_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (evt_valid && evt_cause[C_PRI_UP] && !evt_cause[C_SEC_UP]) |=> ref_sel);
  // R3
  sec_back_sel_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (evt_valid && evt_cause[C_SEC_UP]) |=> !ref_sel);
  // R6
  hold_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (evt_valid && evt_cause[C_HOLD_IN] && !evt_ready) |=> !evt_ready);
  // R8
  clr_ready_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_clr && !evt_valid && !tmr_expire) |=> !evt_ready);
  // R5
  imm_ready_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (evt_valid && evt_cause != 8'h00 && !evt_cause[C_HOLD_IN]) |=> evt_ready);
endmodule

// File: tb/clk_redund_evt_cnt_bench.sv
module clk_redund_evt_cnt_bench;
  localparam int CW = 4;
  localparam int NC = 11;
  localparam int TMR = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_valid = 1'b0;
  logic [7:0] evt_cause = 8'h00;
  logic pri_lost_alarm = 1'b0;
  logic sec_lost_alarm = 1'b0;
  logic ref_active = 1'b0;
  logic rd_clr = 1'b0;
  logic ref_sel, evt_ready;
  logic [NC*CW-1:0] cnt_flat;

  int checks = 0;
  int errors = 0;
  int exp_cnt [NC];

  always #2 clk = ~clk;

  clk_redund_evt_cnt #(.CNT_W(CW), .TMR_CYCLES(TMR)) u_clk_redund_evt_cnt (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_cause(evt_cause),
    .pri_lost_alarm(pri_lost_alarm), .sec_lost_alarm(sec_lost_alarm),
    .ref_active(ref_active), .rd_clr(rd_clr), .ref_sel(ref_sel),
    .evt_ready(evt_ready), .cnt_flat(cnt_flat)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_cnts(string req);
    for (int k = 0; k < NC; k++)
      chk($sformatf("%s cnt%0d", req, k), int'(cnt_flat[k*CW +: CW]), exp_cnt[k]);
  endtask

  task automatic send(logic [7:0] c);
    @(negedge clk);
    evt_valid = 1'b1;
    evt_cause = c;
    @(negedge clk);
    evt_valid = 1'b0;
    evt_cause = 8'h00;
  endtask

  task automatic bump(int k);
    if (exp_cnt[k] < (1 << CW) - 1) exp_cnt[k]++;
  endtask

  task automatic do_clear();
    @(negedge clk);
    rd_clr = 1'b1;
    @(negedge clk);
    rd_clr = 1'b0;
    for (int k = 0; k < NC; k++) exp_cnt[k] = 0;
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int k = 0; k < NC; k++) exp_cnt[k] = 0;
    chk_cnts("R8 reset");
    chk("R3 reset sel", ref_sel, 0);
    chk("R5 reset ready", evt_ready, 0);
  endtask

  task automatic t_loss();
    sec_lost_alarm = 1'b0; send(8'h01); bump(1);
    chk_cnts("R1 pri lost alone");
    sec_lost_alarm = 1'b1; send(8'h01); bump(0);
    chk_cnts("R1 pri lost both");
    sec_lost_alarm = 1'b0;
    pri_lost_alarm = 1'b0; send(8'h04); bump(2);
    chk_cnts("R2 sec lost alone");
    pri_lost_alarm = 1'b1; send(8'h04); bump(0);
    chk_cnts("R2 sec lost both");
    pri_lost_alarm = 1'b0;
  endtask

  task automatic t_back();
    send(8'h02); bump(3);
    chk("R3 pri back sel", ref_sel, 1);
    send(8'h08); bump(4);
    chk("R3 sec back sel", ref_sel, 0);
    send(8'h02); bump(3);
    send(8'h0A); bump(3); bump(4);
    chk("R3 both back sel", ref_sel, 0);
    chk_cnts("R3 back counts");
  endtask

  task automatic t_misc();
    do_clear();
    chk("R8 clear ready", evt_ready, 0);
    send(8'h80); bump(10);
    chk("R5 immediate ready", evt_ready, 1);
    send(8'h20); bump(8);
    send(8'h40); bump(9);
    chk_cnts("R4 holdover exit and lock");
  endtask

  task automatic t_hold_combo();
    do_clear();
    send(8'h50); bump(7); bump(9);
    chk("R6 entry with others no ready", evt_ready, 0);
    chk_cnts("R6 entry counts");
    wait_cyc(TMR - 1);
    chk("R6 ready one before", evt_ready, 0);
    wait_cyc(1);
    chk("R6 ready at expiry", evt_ready, 1);
    chk_cnts("R7 no switchover");
  endtask

  task automatic t_swo();
    do_clear();
    ref_active = 1'b0;
    send(8'h02); bump(3);
    do_clear();
    send(8'h10); bump(7);
    wait_cyc(5);
    ref_active = 1'b1;
    wait_cyc(TMR - 5);
    bump(5);
    chk_cnts("R7 switch to primary");
    chk("R7 ready", evt_ready, 1);
    send(8'h08); bump(4);
    do_clear();
    send(8'h10); bump(7);
    wait_cyc(3);
    ref_active = 1'b0;
    wait_cyc(TMR - 3);
    bump(6);
    chk_cnts("R7 switch to secondary");
  endtask

  task automatic t_restart();
    do_clear();
    send(8'h10); bump(7);
    wait_cyc(10);
    send(8'h10); bump(7);
    wait_cyc(TMR - 1);
    chk("R10 no early ready", evt_ready, 0);
    wait_cyc(1);
    chk("R10 ready after restart", evt_ready, 1);
    chk_cnts("R10 counts");
  endtask

  task automatic t_clr_inc();
    send(8'h80); bump(10);
    @(negedge clk);
    rd_clr = 1'b1; evt_valid = 1'b1; evt_cause = 8'h20;
    @(negedge clk);
    rd_clr = 1'b0; evt_valid = 1'b0; evt_cause = 8'h00;
    for (int k = 0; k < NC; k++) exp_cnt[k] = 0;
    exp_cnt[8] = 1;
    chk_cnts("R8 clear with increment");
    chk("R8 ready after clear with event", evt_ready, 1);
  endtask

  task automatic t_sat();
    do_clear();
    for (int i = 0; i < 18; i++) begin
      send(8'h40); bump(9);
    end
    chk("R9 saturate", int'(cnt_flat[9*CW +: CW]), (1 << CW) - 1);
    chk_cnts("R9 others");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_loss();
    t_back();
    t_misc();
    t_hold_combo();
    t_swo();
    t_restart();
    t_clr_inc();
    t_sat();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule